// File: doc/BRIEF.md
# CRC-16 Engine with Block Scanner

This block computes a 16-bit cyclic redundancy check with the generator polynomial 0x1021. It consumes one whole byte per clock cycle. Host logic can feed bytes one at a time through a simple write strobe. It can also start an autonomous scan, which walks one or more 256-byte blocks of a memory through a synchronous read port. Each scanned byte is folded into the same checksum register.

Before a sequence, the host loads a seed of all zeros or all ones. The engine can also run in reflected form. In that form each input byte is bit-reversed before it is folded in, and each byte of the result is bit-reversed on the way out. A scan continues from whatever value the register holds, so the host loads the seed first. While a scan runs, `busy` is high. A one-cycle `done` pulse marks the end of the scan.

Top module: `crc16_scan`

## Requirements
- R1: With reflection off, each accepted byte is folded in most significant bit first using polynomial 0x1021, one byte per cycle. The new value appears on `crc_out` in the cycle after the byte is accepted. The string "123456789" gives 0x29B1 from seed 0xFFFF and 0x31C3 from seed 0x0000.
- R2: When `init_req` is accepted, the register is loaded with 0xFFFF if `seed_ones` is 1 and with 0x0000 if it is 0. The loaded value is visible in the next cycle. If `init_req` and `wr_valid` arrive in the same cycle, the seed wins and the byte is dropped.
- R3: With `reflect` high, each input byte has its bit order reversed before folding (input bit 0 enters first). `crc_out` then shows each of its two bytes with the bits reversed in place, so bit 15 is swapped with bit 8 and bit 7 with bit 0.
- R4: An accepted `scan_start` with a nonzero `scan_count` reads the addresses from `scan_first_blk`×256 upward, one per cycle, over exactly `scan_count`×256 consecutive addresses. The first address has its low 8 bits equal to zero. Addresses wrap modulo 2^ADDR_W.
- R5: Read data returns one cycle after `mem_rd_en` and is folded into the register at that point. `mem_rd_en` is only ever high while `busy` is high.
- R6: `busy` goes high in the cycle after an accepted start and stays high until the last read byte is folded. `done` is then high for exactly one cycle, in the same cycle that `busy` is low again. At that point `crc_out` already holds the final value.
- R7: While `busy` is high, `wr_valid`, `init_req` and `scan_start` are all ignored.
- R8: A `scan_start` with `scan_count` equal to 0 is ignored: `busy` stays low and no read is issued.
- R9: After reset, `crc_out` is 0x0000 and `busy`, `done` and `mem_rd_en` are low. With no accepted byte, seed load or scan, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_ones | input | 1 | Seed select: 1 gives 0xFFFF, 0 gives 0x0000 |
| reflect | input | 1 | Bit-reversed input bytes and result bytes |
| init_req | input | 1 | Load the selected seed |
| wr_valid | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to fold in |
| scan_start | input | 1 | Start a block scan |
| scan_first_blk | input | ADDR_W-8 | Index of the first 256-byte block |
| scan_count | input | CNT_W | Number of blocks to scan |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when a scan completes |
| crc_out | output | 16 | Checksum, mapped by `reflect` |

## Verification
A written byte or a seed load shows on `crc_out` one cycle after the clock edge that accepts it. The bench drives each input on the falling edge and reads the result on the next falling edge. A scan issues its first read address in the cycle after the start. It takes N×256 read cycles plus one drain cycle, and `done` is high in the cycle after the last fold. The bench therefore checks each address on every falling edge while `mem_rd_en` is high. It compares the checksum only on the edge where `done` is seen. Writes and seed loads injected mid-scan must leave that final value equal to the pure scan model.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    SCAN_IDLE  = 2'd0,
    SCAN_RUN   = 2'd1,
    SCAN_DRAIN = 2'd2
  } scan_state_e;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/crc16_step.sv
module crc16_step
  import crc16_pkg::*;
#(
  parameter int          CRC_W  = 16,
  parameter int          BYTE_W = 8,
  parameter logic [15:0] POLY   = CRC_POLY
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              reflect,
  output logic [CRC_W-1:0]  crc_out
);
  localparam int SHIFT = CRC_W - BYTE_W;

  logic [BYTE_W-1:0] byte_ord;
  logic [CRC_W-1:0]  acc;

  always_comb begin
    byte_ord = reflect ? rev8(byte_in) : byte_in;
    acc      = crc_in ^ ({{SHIFT{1'b0}}, byte_ord} << SHIFT);
    for (int i = 0; i < BYTE_W; i++) begin
      if (acc[CRC_W-1]) acc = (acc << 1) ^ POLY;
      else              acc = acc << 1;
    end
    crc_out = acc;
  end
endmodule

// File: rtl/crc16_walker.sv
module crc16_walker
  import crc16_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = ADDR_W - 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-9:0] first_blk,
  input  logic [CNT_W-1:0]  blk_count,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_vld,
  output logic              busy,
  output logic              done
);
  localparam int BLK_W = ADDR_W - 8;

  scan_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              vld_q, done_q;
  logic              pos_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    left_d  = left_q;
    pos_en  = 1'b0;
    case (state_q)
      SCAN_IDLE: begin
        if (start && (blk_count != '0)) begin
          state_d = SCAN_RUN;
          addr_d  = {first_blk[BLK_W-1:0], 8'h00};
          left_d  = blk_count;
          pos_en  = 1'b1;
        end
      end
      SCAN_RUN: begin
        pos_en = 1'b1;
        addr_d = addr_q + 1'b1;
        if (addr_q[7:0] == 8'hFF) begin
          left_d = left_q - 1'b1;
          if (left_q == {{(CNT_W-1){1'b0}}, 1'b1}) state_d = SCAN_DRAIN;
        end
      end
      SCAN_DRAIN: state_d = SCAN_IDLE;
      default:    state_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= (state_q == SCAN_RUN);
      done_q  <= (state_q == SCAN_DRAIN);
      if (pos_en) begin
        addr_q <= addr_d;
        left_q <= left_d;
      end
    end
  end

  assign rd_en   = (state_q == SCAN_RUN);
  assign rd_addr = addr_q;
  assign rd_vld  = vld_q;
  assign busy    = (state_q != SCAN_IDLE);
  assign done    = done_q;
endmodule

// File: rtl/crc16_scan.sv
module crc16_scan
  import crc16_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = ADDR_W - 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_ones,
  input  logic              reflect,
  input  logic              init_req,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              scan_start,
  input  logic [ADDR_W-9:0] scan_first_blk,
  input  logic [CNT_W-1:0]  scan_count,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic [15:0]       crc_out
);
  localparam int CRC_W   = 16;
  localparam int N_LANES = CRC_W / 8;

  logic [CRC_W-1:0] crc_q, crc_d, step_out;
  logic [7:0]       step_byte;
  logic             scan_vld, load_seed, take_wr, crc_en;

  crc16_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (scan_start),
    .first_blk (scan_first_blk),
    .blk_count (scan_count),
    .rd_en     (mem_rd_en),
    .rd_addr   (mem_rd_addr),
    .rd_vld    (scan_vld),
    .busy      (busy),
    .done      (done)
  );

  crc16_step #(.CRC_W(CRC_W), .BYTE_W(8)) u_step (
    .crc_in  (crc_q),
    .byte_in (step_byte),
    .reflect (reflect),
    .crc_out (step_out)
  );

  always_comb begin
    load_seed = init_req && !busy;
    take_wr   = wr_valid && !busy && !init_req;
    step_byte = scan_vld ? mem_rd_data : wr_data;
    crc_en    = load_seed || take_wr || scan_vld;
    crc_d     = load_seed ? {CRC_W{seed_ones}} : step_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign crc_out[g*8 +: 8] = reflect ? rev8(crc_q[g*8 +: 8]) : crc_q[g*8 +: 8];
  end
endmodule

// File: rtl/crc16_scan_chk.sv
module crc16_scan_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = ADDR_W - 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seed_ones,
  input logic              reflect,
  input logic              init_req,
  input logic              wr_valid,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              busy,
  input logic              done,
  input logic [15:0]       crc_out
);
  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && !busy) |=> (crc_out == {16{$past(seed_ones)}})); // R2
  AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_rd_en && mem_rd_addr[7:0] == 8'h00)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1)); // R4
  AST_READ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_valid && !init_req) |=>
      ((crc_out == $past(crc_out)) || (reflect != $past(reflect)))); // R9
endmodule

bind crc16_scan crc16_scan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .seed_ones   (seed_ones),
  .reflect     (reflect),
  .init_req    (init_req),
  .wr_valid    (wr_valid),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .busy        (busy),
  .done        (done),
  .crc_out     (crc_out)
);

// File: tb/crc16_scan_tb.sv
`timescale 1ns/1ps
module crc16_scan_tb;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = ADDR_W - 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              seed_ones, reflect, init_req, wr_valid, scan_start;
  logic [7:0]        wr_data, mem_rd_data;
  logic [ADDR_W-9:0] scan_first_blk;
  logic [CNT_W-1:0]  scan_count;
  logic              mem_rd_en, busy, done;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [15:0]       crc_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] model;

  always #4 clk = ~clk;

  crc16_scan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .seed_ones(seed_ones), .reflect(reflect),
    .init_req(init_req), .wr_valid(wr_valid), .wr_data(wr_data),
    .scan_start(scan_start), .scan_first_blk(scan_first_blk),
    .scan_count(scan_count), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .busy(busy), .done(done), .crc_out(crc_out)
  );

  function automatic logic [7:0] memf(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ (a[15:8] * 8'd29) ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);

  function automatic logic [7:0] flip(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  function automatic logic [15:0] fold(input logic [15:0] c, input logic [7:0] b, input logic refl);
    logic [7:0] d;
    d = refl ? flip(b) : b;
    for (int i = 7; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [15:0] shown(input logic [15:0] c, input logic refl);
    return refl ? {flip(c[15:8]), flip(c[7:0])} : c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_init(input logic ones);
    seed_ones = ones; init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    model = {16{ones}};
  endtask

  task automatic put(input logic [7:0] b);
    wr_data = b; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
    model = fold(model, b, reflect);
  endtask

  task automatic run_scan(input logic [ADDR_W-9:0] blk, input logic [CNT_W-1:0] n, input bit noise, input string tag);
    logic [ADDR_W-1:0] ea;
    int reads;
    bit addr_ok, seen;
    ea = {blk, 8'h00};
    for (int k = 0; k < int'(n) * 256; k++) model = fold(model, memf(ea + ADDR_W'(k)), reflect);
    scan_first_blk = blk; scan_count = n; scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    chk(busy === 1'b1, {tag, " R6 busy after start"}, busy, 1);
    reads = 0; addr_ok = 1'b1; seen = 1'b0;
    for (int t = 0; t < 300000 && !seen; t++) begin
      if (mem_rd_en) begin
        if (mem_rd_addr !== ea) addr_ok = 1'b0;
        ea++; reads++;
      end
      if (done) begin
        seen = 1'b1;
        chk(busy === 1'b0, {tag, " R6 busy low at done"}, busy, 0);
        chk(crc_out === shown(model, reflect), {tag, " R5 scan result"}, crc_out, shown(model, reflect));
      end else begin
        if (noise) begin
          init_req = $urandom_range(0, 1); seed_ones = ~seed_ones;
          wr_valid = $urandom_range(0, 1); wr_data = 8'($urandom);
          scan_start = $urandom_range(0, 1); // R7 all ignored while busy
        end
        @(negedge clk);
        init_req = 1'b0; wr_valid = 1'b0; scan_start = 1'b0;
      end
    end
    chk(seen, {tag, " R6 done seen"}, seen, 1);
    chk(addr_ok, {tag, " R4 address sequence"}, addr_ok, 1);
    chk(reads == int'(n) * 256, {tag, " R4 read count"}, reads, int'(n) * 256);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R6 done single cycle"}, done, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ascii [9];
    void'($urandom(32'h1D2C));
    rst_n = 1'b0; seed_ones = 0; reflect = 0; init_req = 0; wr_valid = 0; wr_data = 0;
    scan_start = 0; scan_first_blk = 0; scan_count = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(crc_out === 16'h0000, "R9 reset crc", crc_out, 0);
    chk({busy, done, mem_rd_en} === 3'b000, "R9 reset flags", {busy, done, mem_rd_en}, 0);

    for (int i = 0; i < 9; i++) ascii[i] = 8'h31 + 8'(i);
    do_init(1'b1);
    chk(crc_out === 16'hFFFF, "R2 seed ones", crc_out, 16'hFFFF);
    for (int i = 0; i < 9; i++) put(ascii[i]);
    chk(crc_out === 16'h29B1, "R1 known vector seed ffff", crc_out, 16'h29B1);
    do_init(1'b0);
    chk(crc_out === 16'h0000, "R2 seed zero", crc_out, 0);
    for (int i = 0; i < 9; i++) put(ascii[i]);
    chk(crc_out === 16'h31C3, "R1 known vector seed 0000", crc_out, 16'h31C3);

    // R2 init wins over a simultaneous write
    wr_valid = 1'b1; wr_data = 8'hA5; seed_ones = 1'b1; init_req = 1'b1;
    @(negedge clk); wr_valid = 1'b0; init_req = 1'b0; model = 16'hFFFF;
    chk(crc_out === 16'hFFFF, "R2 init beats write", crc_out, 16'hFFFF);

    // R9 hold when idle
    repeat (4) @(negedge clk);
    chk(crc_out === 16'hFFFF, "R9 hold idle", crc_out, 16'hFFFF);

    // R1 / R3 random byte streams, each check per byte
    for (int s = 0; s < 6; s++) begin
      reflect = s[0];
      do_init(s[1]);
      for (int i = 0; i < 40; i++) begin
        put(8'($urandom));
        chk(crc_out === shown(model, reflect), reflect ? "R3 reflected stream" : "R1 plain stream",
            crc_out, shown(model, reflect));
      end
    end
    // R3 readback mapping toggles live
    reflect = 1'b0; @(negedge clk);
    chk(crc_out === model, "R3 unmapped view", crc_out, model);
    reflect = 1'b1; @(negedge clk);
    chk(crc_out === shown(model, 1'b1), "R3 mapped view", crc_out, shown(model, 1'b1));

    // R8 zero count ignored
    scan_first_blk = 8'd7; scan_count = '0; scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    repeat (2) @(negedge clk);
    chk({busy, mem_rd_en} === 2'b00, "R8 zero count no scan", {busy, mem_rd_en}, 0);
    chk(crc_out === shown(model, reflect), "R8 crc unchanged", crc_out, shown(model, reflect));

    reflect = 1'b0; do_init(1'b1);
    run_scan(8'd3, 9'd2, 1'b0, "scanA");
    reflect = 1'b1; do_init(1'b0);
    run_scan(8'd255, 9'd1, 1'b1, "scanB R7");
    reflect = 1'b0; do_init(1'b0);
    run_scan(8'd254, 9'd3, 1'b1, "scanC wrap R7");
    reflect = 1'b0; put(8'h3C);
    chk(crc_out === model, "R1 write after scan", crc_out, model);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule